// File: doc/BRIEF.md
# XON/XOFF Software Flow Control Engine

This block adds in-band software flow control to one UART channel. It sits between the receive deserializer and the receive data consumer, and between the transmit data source and the serializer. Four programmable 8-bit characters form two pairs: pair one (`xon1Char`/`xoff1Char`) and pair two (`xon2Char`/`xoff2Char`). Received bytes are compared against the pairs enabled for receive. A recognised XOFF pauses the transmitter, a recognised XON releases it, and the completing flow character is removed from the receive stream. On the transmit side, a single-cycle request injects the XON or XOFF characters of the pairs enabled for transmit ahead of normal data.

A 4-bit mode word selects the behaviour. Bits 3:2 select the transmit pairs and bits 1:0 select the receive pairs. In both fields, 10 means pair one, 01 means pair two, 11 means both pairs and 00 means off. A control bit lets any received byte release the transmit hold. A pending-interrupt flag, gated by its own enable, reports each recognised flow character. Two status outputs report whether the transmitter is held and whether the last flow sequence sent was an XOFF.

Top module: `swfc_engine`

## Requirements
- R1: After reset, `txHold`, `xoffSent`, `irqPending` and `rxOutValid` are 0, and `txValid` follows `dataValid`, carrying `dataByte`.
- R2: With receive field `cfgMode[1:0]` = 10, a received byte equal to `xoff1Char` sets `txHold` on the edge it is strobed, and a byte equal to `xon1Char` clears it. With field 01, `xoff2Char` and `xon2Char` act the same way, and the pair-one characters are ordinary data. If an XOFF and an XON character are equal, the XOFF meaning wins.
- R3: With receive field 11, an XOFF is recognised only when `xoff2Char` is the received byte that immediately follows `xoff1Char`, and an XON only when `xon2Char` immediately follows `xon1Char`. Any other byte between them cancels the partial match. The first character of a pair is passed on as data.
- R4: Every received byte that is not a completing flow character appears on `rxOutValid`/`rxOutByte` one cycle after its strobe. A completing flow character produces no output strobe.
- R5: With receive field 00, no byte is recognised, every byte is passed on, and `txHold` is 0 from the next cycle.
- R6: With `cfgAnyResume` = 1, any received byte that does not complete an XOFF clears `txHold`.
- R7: While `txHold` is 1, normal data is not offered (`txValid` = 0 and `dataTake` = 0 unless a flow character is pending), while flow characters are still offered.
- R8: On `txReqXoff` or `txReqXon`, the transmit field `cfgMode[3:2]` selects the bytes sent: 10 sends the pair-one character, 01 sends the pair-two character, and 11 sends the pair-one character and then the pair-two character. Field 00 ignores requests and drops a sequence in progress.
- R9: A pending flow sequence is offered from the cycle after the request, ahead of normal data. `dataTake` stays 0 until the last flow byte has been granted. A request that arrives while a sequence is in progress is ignored. A simultaneous XOFF and XON request sends XOFF.
- R10: `xoffSent` becomes 1 on the grant of the final byte of an XOFF sequence and becomes 0 on the grant of the final byte of an XON sequence.
- R11: With `cfgIrqEn` = 1, recognising a flow character sets `irqPending`, which stays 1 until `irqClear`. A new recognition in the same cycle as `irqClear` wins. With `cfgIrqEn` = 0, recognition does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgMode | input | 4 | Bits 3:2 select the transmit pairs, bits 1:0 select the receive pairs |
| cfgAnyResume | input | 1 | Any received byte releases the hold |
| cfgIrqEn | input | 1 | Enables setting of `irqPending` |
| xon1Char | input | CHAR_W | XON character of pair one |
| xon2Char | input | CHAR_W | XON character of pair two |
| xoff1Char | input | CHAR_W | XOFF character of pair one |
| xoff2Char | input | CHAR_W | XOFF character of pair two |
| rxValid | input | 1 | Received-byte strobe |
| rxByte | input | CHAR_W | Received byte |
| rxOutValid | output | 1 | Passed-on receive byte strobe |
| rxOutByte | output | CHAR_W | Passed-on receive byte |
| txReqXoff | input | 1 | Request to send the XOFF sequence |
| txReqXon | input | 1 | Request to send the XON sequence |
| dataValid | input | 1 | Normal transmit data available |
| dataByte | input | CHAR_W | Normal transmit data |
| dataTake | output | 1 | Normal data byte consumed this cycle |
| txValid | output | 1 | Byte offered to the serializer |
| txByte | output | CHAR_W | Byte offered to the serializer |
| txGrant | input | 1 | Serializer accepts the offered byte |
| txHold | output | 1 | Transmitter held by a received XOFF |
| xoffSent | output | 1 | Last completed flow sequence was XOFF |
| irqPending | output | 1 | Flow character recognised |
| irqClear | input | 1 | Clears `irqPending` |

## Verification
The properties assume that the serializer raises `txGrant` only while `txValid` is 1. They also assume that `cfgMode` changes only between received bytes, and not while a two-byte transmit sequence is half sent. The stimulus sets the mode in the same cycle as the byte or request it applies to. It grants only bytes that it has just seen offered, and it lets each transmit sequence finish before it changes the transmit field. The flow characters are distinct from each other and from the data byte, so every byte the bench expects to see identifies which path produced it.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
  localparam int CHAR_W_DEF = 8;
  localparam int NUM_FLOW = 4;
  localparam int IDX_W = $clog2(NUM_FLOW);

  // character slot order: {isXoff, isPair2}
  localparam int SLOT_XON1  = 0;
  localparam int SLOT_XON2  = 1;
  localparam int SLOT_XOFF1 = 2;
  localparam int SLOT_XOFF2 = 3;

  localparam logic [1:0] FLD_OFF   = 2'b00;
  localparam logic [1:0] FLD_PAIR2 = 2'b01;
  localparam logic [1:0] FLD_PAIR1 = 2'b10;
  localparam logic [1:0] FLD_BOTH  = 2'b11;

  typedef enum logic [1:0] {
    PART_NONE  = 2'd0,
    PART_XON1  = 2'd1,
    PART_XOFF1 = 2'd2
  } partial_e;

  typedef struct packed {
    logic xon1;
    logic xon2;
    logic xoff1;
    logic xoff2;
  } hits_t;

  typedef struct packed {
    logic rxPass;
    logic flowActive;
    logic flowXoff;
    logic flowPair2;
    logic dataBlock;
  } strobes_t;
endpackage

// File: rtl/swfc_dp.sv
module swfc_dp
  import swfc_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_FLOW-1:0][CHAR_W-1:0]  flowChars,
  input  logic                             rxValid,
  input  logic [CHAR_W-1:0]                rxByte,
  output hits_t                            hits,
  input  strobes_t                         strb,
  input  logic                             dataValid,
  input  logic [CHAR_W-1:0]                dataByte,
  input  logic                             txGrant,
  output logic                             dataTake,
  output logic                             txValid,
  output logic [CHAR_W-1:0]                txByte,
  output logic                             rxOutValid,
  output logic [CHAR_W-1:0]                rxOutByte
);
  logic [NUM_FLOW-1:0] hitVec;
  logic [IDX_W-1:0]    flowSlot;
  logic [CHAR_W-1:0]   flowByte;

  for (genvar g = 0; g < NUM_FLOW; g++) begin : gCmp
    assign hitVec[g] = rxValid && (rxByte == flowChars[g]);
  end

  always_comb begin
    hits.xon1  = hitVec[SLOT_XON1];
    hits.xon2  = hitVec[SLOT_XON2];
    hits.xoff1 = hitVec[SLOT_XOFF1];
    hits.xoff2 = hitVec[SLOT_XOFF2];
  end

  assign flowSlot = {strb.flowXoff, strb.flowPair2};
  assign flowByte = flowChars[flowSlot];

  always_comb begin
    if (strb.flowActive) begin
      txValid  = 1'b1;
      txByte   = flowByte;
      dataTake = 1'b0;
    end else begin
      txValid  = dataValid && !strb.dataBlock;
      txByte   = dataByte;
      dataTake = txGrant && dataValid && !strb.dataBlock;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxOutValid <= 1'b0;
      rxOutByte  <= '0;
    end else begin
      rxOutValid <= strb.rxPass;
      if (strb.rxPass) rxOutByte <= rxByte;
    end
  end
endmodule

// File: rtl/swfc_ctrl.sv
module swfc_ctrl
  import swfc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] cfgMode,
  input  logic       cfgAnyResume,
  input  logic       cfgIrqEn,
  input  logic       irqClear,
  input  logic       rxValid,
  input  hits_t      hits,
  input  logic       txReqXoff,
  input  logic       txReqXon,
  input  logic       txGrant,
  output strobes_t   strb,
  output logic       txHold,
  output logic       xoffSent,
  output logic       irqPending
);
  logic [1:0] rxField;
  logic [1:0] txField;
  partial_e   partial;
  partial_e   partialNext;
  logic       xoffDone;
  logic       xonDone;
  logic       busy;
  logic       kindXoff;
  logic       pair2;
  logic       lastByte;

  assign rxField = cfgMode[1:0];
  assign txField = cfgMode[3:2];

  // receive recognition
  always_comb begin
    xoffDone    = 1'b0;
    xonDone     = 1'b0;
    partialNext = PART_NONE;
    unique case (rxField)
      FLD_PAIR1: begin
        xoffDone = hits.xoff1;
        xonDone  = hits.xon1 && !hits.xoff1;
      end
      FLD_PAIR2: begin
        xoffDone = hits.xoff2;
        xonDone  = hits.xon2 && !hits.xoff2;
      end
      FLD_BOTH: begin
        xoffDone = (partial == PART_XOFF1) && hits.xoff2;
        xonDone  = (partial == PART_XON1) && hits.xon2 && !xoffDone;
        if (rxValid && !(xoffDone || xonDone)) begin
          if (hits.xoff1)     partialNext = PART_XOFF1;
          else if (hits.xon1) partialNext = PART_XON1;
        end else if (!rxValid) begin
          partialNext = partial;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      partial <= PART_NONE;
      txHold  <= 1'b0;
    end else begin
      partial <= partialNext;
      if (rxField == FLD_OFF) begin
        txHold <= 1'b0;
      end else if (rxValid) begin
        if (xoffDone)          txHold <= 1'b1;
        else if (xonDone)      txHold <= 1'b0;
        else if (cfgAnyResume) txHold <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPending <= 1'b0;
    end else if ((xoffDone || xonDone) && cfgIrqEn) begin
      irqPending <= 1'b1;
    end else if (irqClear) begin
      irqPending <= 1'b0;
    end
  end

  // transmit injection
  assign lastByte = (txField != FLD_BOTH) || pair2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      kindXoff <= 1'b0;
      pair2    <= 1'b0;
      xoffSent <= 1'b0;
    end else if (txField == FLD_OFF) begin
      busy <= 1'b0;
    end else if (!busy) begin
      if (txReqXoff || txReqXon) begin
        busy     <= 1'b1;
        kindXoff <= txReqXoff;
        pair2    <= (txField == FLD_PAIR2);
      end
    end else if (txGrant) begin
      if (lastByte) begin
        busy     <= 1'b0;
        xoffSent <= kindXoff;
      end else begin
        pair2 <= 1'b1;
      end
    end
  end

  always_comb begin
    strb.rxPass     = rxValid && !(xoffDone || xonDone);
    strb.flowActive = busy;
    strb.flowXoff   = kindXoff;
    strb.flowPair2  = pair2;
    strb.dataBlock  = txHold;
  end
endmodule

// File: rtl/swfc_engine.sv
module swfc_engine
  import swfc_pkg::*;
#(
  parameter int CHAR_W = CHAR_W_DEF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        cfgMode,
  input  logic              cfgAnyResume,
  input  logic              cfgIrqEn,
  input  logic [CHAR_W-1:0] xon1Char,
  input  logic [CHAR_W-1:0] xon2Char,
  input  logic [CHAR_W-1:0] xoff1Char,
  input  logic [CHAR_W-1:0] xoff2Char,
  input  logic              rxValid,
  input  logic [CHAR_W-1:0] rxByte,
  output logic              rxOutValid,
  output logic [CHAR_W-1:0] rxOutByte,
  input  logic              txReqXoff,
  input  logic              txReqXon,
  input  logic              dataValid,
  input  logic [CHAR_W-1:0] dataByte,
  output logic              dataTake,
  output logic              txValid,
  output logic [CHAR_W-1:0] txByte,
  input  logic              txGrant,
  output logic              txHold,
  output logic              xoffSent,
  output logic              irqPending,
  input  logic              irqClear
);
  logic [NUM_FLOW-1:0][CHAR_W-1:0] flowChars;
  hits_t    hits;
  strobes_t ctlStrb;

  always_comb begin
    flowChars[SLOT_XON1]  = xon1Char;
    flowChars[SLOT_XON2]  = xon2Char;
    flowChars[SLOT_XOFF1] = xoff1Char;
    flowChars[SLOT_XOFF2] = xoff2Char;
  end

  swfc_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgAnyResume(cfgAnyResume),
    .cfgIrqEn(cfgIrqEn), .irqClear(irqClear), .rxValid(rxValid), .hits(hits),
    .txReqXoff(txReqXoff), .txReqXon(txReqXon), .txGrant(txGrant),
    .strb(ctlStrb), .txHold(txHold), .xoffSent(xoffSent), .irqPending(irqPending)
  );

  swfc_dp #(.CHAR_W(CHAR_W)) uDp (
    .clk(clk), .rstN(rstN), .flowChars(flowChars), .rxValid(rxValid),
    .rxByte(rxByte), .hits(hits), .strb(ctlStrb), .dataValid(dataValid),
    .dataByte(dataByte), .txGrant(txGrant), .dataTake(dataTake),
    .txValid(txValid), .txByte(txByte), .rxOutValid(rxOutValid),
    .rxOutByte(rxOutByte)
  );
endmodule

// File: rtl/swfc_checker.sv
module swfc_checker #(
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        rxField,
  input logic              cfgIrqEn,
  input logic              rxValid,
  input logic [CHAR_W-1:0] rxByte,
  input logic [CHAR_W-1:0] xon1Char,
  input logic [CHAR_W-1:0] xoff1Char,
  input logic              rxOutValid,
  input logic [CHAR_W-1:0] rxOutByte,
  input logic              txHold,
  input logic              dataTake,
  input logic              txGrant,
  input logic              txValid,
  input logic              xoffSent,
  input logic              irqPending,
  input logic              flowActive
);
  AST_XOFF1_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && rxField == 2'b10 && rxByte == xoff1Char |=> txHold); // R2

  AST_FLOW_CONSUMED: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && rxField == 2'b10 && (rxByte == xoff1Char || rxByte == xon1Char)
    |=> !rxOutValid); // R4

  AST_OFF_PASSES: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && rxField == 2'b00 |=> rxOutValid && rxOutByte == $past(rxByte)); // R5

  AST_OFF_NO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    rxField == 2'b00 |=> !txHold); // R5

  AST_HOLD_NO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    txHold |-> !dataTake); // R7

  AST_FLOW_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    flowActive |-> !dataTake && txValid); // R9

  AST_SENT_ON_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xoffSent) |-> $past(txGrant && flowActive)); // R10

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqPending) |-> $past(cfgIrqEn)); // R11
endmodule

bind swfc_engine swfc_checker #(.CHAR_W(CHAR_W)) uChk (
  .clk(clk), .rstN(rstN), .rxField(cfgMode[1:0]), .cfgIrqEn(cfgIrqEn),
  .rxValid(rxValid), .rxByte(rxByte), .xon1Char(xon1Char), .xoff1Char(xoff1Char),
  .rxOutValid(rxOutValid), .rxOutByte(rxOutByte), .txHold(txHold),
  .dataTake(dataTake), .txGrant(txGrant), .txValid(txValid),
  .xoffSent(xoffSent), .irqPending(irqPending), .flowActive(ctlStrb.flowActive)
);

// File: tb/tb_swfc_engine.sv
module tb_swfc_engine;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;
  localparam logic [7:0] XON1 = 8'h11, XON2 = 8'h21, XOFF1 = 8'h13, XOFF2 = 8'h23;
  localparam logic [7:0] DATA = 8'hA5;
  localparam int NVEC = 22;

  // {req[3:0], rxField[1:0], anyResume, byte[7:0], expValid, expByte[7:0], expHold}
  localparam logic [24:0] RXV [NVEC] = '{
    {4'd4, 2'b10, 1'b0, 8'h41, 1'b1, 8'h41, 1'b0},  // R4 plain data
    {4'd2, 2'b10, 1'b0, XOFF1, 1'b0, 8'h00, 1'b1},  // R2 xoff1
    {4'd4, 2'b10, 1'b0, 8'h42, 1'b1, 8'h42, 1'b1},  // R4 held, data passes
    {4'd2, 2'b10, 1'b0, XOFF2, 1'b1, XOFF2, 1'b1},  // R2 pair two not enabled
    {4'd2, 2'b10, 1'b0, XON1,  1'b0, 8'h00, 1'b0},  // R2 xon1
    {4'd2, 2'b01, 1'b0, XOFF1, 1'b1, XOFF1, 1'b0},  // R2 pair one ignored
    {4'd2, 2'b01, 1'b0, XOFF2, 1'b0, 8'h00, 1'b1},  // R2 xoff2
    {4'd2, 2'b01, 1'b0, XON1,  1'b1, XON1,  1'b1},  // R2
    {4'd2, 2'b01, 1'b0, XON2,  1'b0, 8'h00, 1'b0},  // R2 xon2
    {4'd3, 2'b11, 1'b0, XOFF1, 1'b1, XOFF1, 1'b0},  // R3 first passes
    {4'd3, 2'b11, 1'b0, XOFF2, 1'b0, 8'h00, 1'b1},  // R3 completes xoff
    {4'd3, 2'b11, 1'b0, XON1,  1'b1, XON1,  1'b1},  // R3
    {4'd3, 2'b11, 1'b0, 8'h55, 1'b1, 8'h55, 1'b1},  // R3 breaker
    {4'd3, 2'b11, 1'b0, XON2,  1'b1, XON2,  1'b1},  // R3 not completed
    {4'd3, 2'b11, 1'b0, XON1,  1'b1, XON1,  1'b1},  // R3
    {4'd3, 2'b11, 1'b0, XON2,  1'b0, 8'h00, 1'b0},  // R3 completes xon
    {4'd3, 2'b11, 1'b0, XOFF2, 1'b1, XOFF2, 1'b0},  // R3 lone second
    {4'd6, 2'b10, 1'b1, XOFF1, 1'b0, 8'h00, 1'b1},  // R6 xoff still holds
    {4'd6, 2'b10, 1'b1, 8'h77, 1'b1, 8'h77, 1'b0},  // R6 any byte resumes
    {4'd6, 2'b10, 1'b1, XOFF1, 1'b0, 8'h00, 1'b1},  // R6
    {4'd5, 2'b00, 1'b0, XOFF1, 1'b1, XOFF1, 1'b0},  // R5 off clears hold
    {4'd5, 2'b00, 1'b0, XON1,  1'b1, XON1,  1'b0}   // R5
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] cfgMode = 4'b0000;
  logic cfgAnyResume = 1'b0, cfgIrqEn = 1'b0;
  logic rxValid = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic rxOutValid;
  logic [7:0] rxOutByte;
  logic txReqXoff = 1'b0, txReqXon = 1'b0;
  logic dataValid = 1'b0;
  logic [7:0] dataByte = DATA;
  logic dataTake, txValid;
  logic [7:0] txByte;
  logic txGrant = 1'b0;
  logic txHold, xoffSent, irqPending;
  logic irqClear = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swfc_engine dut (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgAnyResume(cfgAnyResume),
    .cfgIrqEn(cfgIrqEn), .xon1Char(XON1), .xon2Char(XON2), .xoff1Char(XOFF1),
    .xoff2Char(XOFF2), .rxValid(rxValid), .rxByte(rxByte), .rxOutValid(rxOutValid),
    .rxOutByte(rxOutByte), .txReqXoff(txReqXoff), .txReqXon(txReqXon),
    .dataValid(dataValid), .dataByte(dataByte), .dataTake(dataTake),
    .txValid(txValid), .txByte(txByte), .txGrant(txGrant), .txHold(txHold),
    .xoffSent(xoffSent), .irqPending(irqPending), .irqClear(irqClear)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic stepEdge();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    dataValid = 1'b1;
    #1;
    chk("R1 txHold", txHold, 0);
    chk("R1 xoffSent", xoffSent, 0);
    chk("R1 irqPending", irqPending, 0);
    chk("R1 rxOutValid", rxOutValid, 0);
    chk("R1 txValid", txValid, 1);
    chk("R1 txByte", txByte, DATA);

    // receive vector table
    for (int i = 0; i < NVEC; i++) begin
      logic [24:0] v;
      v = RXV[i];
      @(negedge clk);
      cfgMode = {2'b00, v[20:19]};
      cfgAnyResume = v[18];
      rxByte = v[17:10];
      rxValid = 1'b1;
      stepEdge();
      chk($sformatf("R%0d vec%0d rxOutValid", v[24:21], i), rxOutValid, v[9]);
      if (v[9]) chk($sformatf("R%0d vec%0d rxOutByte", v[24:21], i), rxOutByte, v[8:1]);
      chk($sformatf("R%0d vec%0d txHold", v[24:21], i), txHold, v[0]);
      @(negedge clk);
      rxValid = 1'b0;
    end
    cfgAnyResume = 1'b0;
    chk("R11 disabled no irq", irqPending, 0);

    // R8 pair one XOFF
    @(negedge clk);
    cfgMode = 4'b1000;
    txReqXoff = 1'b1;
    stepEdge();
    chk("R8 pair1 xoff byte", txByte, XOFF1);
    chk("R9 flow offered", txValid, 1);
    @(negedge clk);
    txReqXoff = 1'b0;
    txGrant = 1'b1;
    #1;
    chk("R9 no data take during flow", dataTake, 0);
    stepEdge();
    chk("R10 xoffSent set", xoffSent, 1);
    chk("R9 data resumes", txByte, DATA);
    @(negedge clk);
    txGrant = 1'b0;

    // R8 both pairs XON
    @(negedge clk);
    cfgMode = 4'b1100;
    txReqXon = 1'b1;
    stepEdge();
    chk("R8 both first byte", txByte, XON1);
    @(negedge clk);
    txReqXon = 1'b0;
    txGrant = 1'b1;
    stepEdge();
    chk("R8 both second byte", txByte, XON2);
    chk("R10 not final yet", xoffSent, 1);
    stepEdge();
    chk("R10 xoffSent cleared", xoffSent, 0);
    chk("R8 both done data", txByte, DATA);
    @(negedge clk);
    txGrant = 1'b0;

    // R8 pair two XOFF
    @(negedge clk);
    cfgMode = 4'b0100;
    txReqXoff = 1'b1;
    stepEdge();
    chk("R8 pair2 xoff byte", txByte, XOFF2);
    @(negedge clk);
    txReqXoff = 1'b0;
    txGrant = 1'b1;
    stepEdge();
    chk("R10 pair2 xoffSent", xoffSent, 1);
    @(negedge clk);
    txGrant = 1'b0;

    // R8 field off ignores request
    @(negedge clk);
    cfgMode = 4'b0000;
    txReqXon = 1'b1;
    stepEdge();
    chk("R8 off ignores request", txByte, DATA);
    @(negedge clk);
    txReqXon = 1'b0;
    stepEdge();
    chk("R8 off still data", txByte, DATA);

    // R9 simultaneous requests, then request while busy
    @(negedge clk);
    cfgMode = 4'b1000;
    txReqXoff = 1'b1;
    txReqXon = 1'b1;
    stepEdge();
    chk("R9 xoff wins", txByte, XOFF1);
    @(negedge clk);
    txReqXoff = 1'b0;
    txReqXon = 1'b1;
    stepEdge();
    chk("R9 busy keeps sequence", txByte, XOFF1);
    @(negedge clk);
    txReqXon = 1'b0;
    txGrant = 1'b1;
    stepEdge();
    chk("R9 busy request ignored", txByte, DATA);
    chk("R10 xoff from race", xoffSent, 1);
    @(negedge clk);
    txGrant = 1'b0;

    // R7 hold blocks data, not flow characters
    @(negedge clk);
    cfgMode = 4'b1010;
    rxByte = XOFF1;
    rxValid = 1'b1;
    stepEdge();
    chk("R7 hold set", txHold, 1);
    chk("R7 data blocked", txValid, 0);
    @(negedge clk);
    rxValid = 1'b0;
    txReqXon = 1'b1;
    stepEdge();
    chk("R7 flow under hold", txValid, 1);
    chk("R7 flow byte under hold", txByte, XON1);
    @(negedge clk);
    txReqXon = 1'b0;
    txGrant = 1'b1;
    stepEdge();
    chk("R7 blocked after flow", txValid, 0);
    chk("R7 no take while held", dataTake, 0);
    @(negedge clk);
    txGrant = 1'b0;
    rxByte = XON1;
    rxValid = 1'b1;
    stepEdge();
    chk("R7 released", txValid, 1);
    chk("R7 released byte", txByte, DATA);
    @(negedge clk);
    rxValid = 1'b0;

    // R11 interrupt
    @(negedge clk);
    cfgMode = 4'b0010;
    cfgIrqEn = 1'b1;
    rxByte = XOFF1;
    rxValid = 1'b1;
    stepEdge();
    chk("R11 irq set", irqPending, 1);
    @(negedge clk);
    rxValid = 1'b0;
    stepEdge();
    chk("R11 irq sticky", irqPending, 1);
    @(negedge clk);
    irqClear = 1'b1;
    stepEdge();
    chk("R11 irq cleared", irqPending, 0);
    @(negedge clk);
    rxByte = XON1;
    rxValid = 1'b1;
    stepEdge();
    chk("R11 set wins over clear", irqPending, 1);
    @(negedge clk);
    rxValid = 1'b0;
    irqClear = 1'b0;

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule